// File: doc/BRIEF.md
# Predicated Stream Port Pair

This block holds the two ends of a flow-controlled word channel that links compute regions running on separate static schedules. The egress end takes words from a producing region and sends them onto the channel. The ingress end takes words off the channel and hands them to a consuming region. Each end holds its words in a small FIFO. Each region cycle brings a predicate that says whether the scheduled access should really happen. The port raises a stall request when an active access cannot be served. The region's stall network feeds back a hold input. While hold is high, no access completes.

On the channel, a forward valid bit and a reverse ready bit travel with the data word. Ready is a promise: when the receiver shows ready high in one cycle, it can take a word in the next cycle. The sender therefore drives valid only in the cycle after it saw ready high, and every valid cycle is a completed transfer. The egress stall is raised at a programmable fill mark, below full. Words that the region writes before its hold arrives still have room in the FIFO. The ingress end reports empty on its own output, apart from the consume operation, so a schedule can check for data before it uses it.

Top module: `sp_stream_ports`

## Requirements
- R1: After reset both FIFOs are empty. `tx_valid` is low, `rx_ready` is high, `rd_empty` is high, and with both predicates low neither stall is high.
- R2: `wr_stall` is high exactly when `wr_pred` is high and the egress fill level is at or above the effective mark. The effective mark is `wr_mark`, except that 0 counts as 1. The range 1 to DEPTH-1 is used as given.
- R3: An egress write stores `wr_word` exactly when `wr_pred` is high, `wr_hold` is low and the FIFO holds fewer than DEPTH words. The fill level used is the one at the start of the cycle. Writes keep landing between the mark and full.
- R4: `tx_valid` is high only in a cycle after a cycle in which `tx_ready` was high, and only when the egress FIFO is not empty. Each valid cycle sends the oldest word on `tx_word`.
- R5: `rx_ready` is high exactly when the ingress words stored plus the word arriving this cycle (`rx_valid`) come to fewer than DEPTH. Each `rx_valid` cycle stores `rx_word`.
- R6: `rd_stall` is high exactly when `rd_pred` is high and the ingress FIFO is empty.
- R7: A consume removes the oldest ingress word exactly when `rd_pred` is high, `rd_hold` is low and the FIFO is not empty. `rd_word` shows that oldest word whenever the FIFO is not empty.
- R8: `rd_empty` shows the ingress FIFO state whatever the value of `rd_pred`.
- R9: With its predicate low, a port raises no stall and moves no word between the region and the FIFO.
- R10: With `wr_hold` or `rd_hold` high, that side's region access moves no word, even if its predicate is high. Channel traffic goes on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_pred | input | 1 | Egress access predicate |
| wr_hold | input | 1 | Region hold for the egress side |
| wr_word | input | DW | Word to write |
| wr_mark | input | $clog2(DEPTH) | Fill mark for the early stall |
| wr_stall | output | 1 | Egress stall request |
| tx_valid | output | 1 | Channel out word valid |
| tx_word | output | DW | Channel out word |
| tx_ready | input | 1 | Downstream can take a word next cycle |
| rx_valid | input | 1 | Channel in word valid |
| rx_word | input | DW | Channel in word |
| rx_ready | output | 1 | This port can take a word next cycle |
| rd_pred | input | 1 | Ingress access predicate |
| rd_hold | input | 1 | Region hold for the ingress side |
| rd_word | output | DW | Oldest ingress word |
| rd_empty | output | 1 | Ingress FIFO empty |
| rd_stall | output | 1 | Ingress stall request |

## Verification
On each side, a region access and a channel transfer can fall in the same cycle. A word can arrive from the channel in the cycle that the region consumes the last ingress word. The egress FIFO can be full while a word leaves on the channel and the region tries to write. The bench provokes these cases by filling a FIFO to the brim and then opening the far side while the predicate stays high. It also provokes them with long random runs in which hold, predicate, ready and mark change every cycle. A queue-based reference model predicts every output in every cycle. The judgement is that full and empty use the level at the start of the cycle, and that ready counts the word that is arriving.

// File: rtl/sp_stream_pkg.sv
package sp_stream_pkg;

   // Effective fill mark: 0 is raised to 1, anything at or past depth is
   // lowered to depth-1 so a stall always fires before the buffer is full.
   function automatic int unsigned eff_mark(input int unsigned mark,
                                            input int unsigned depth);
      if (mark == 0)
         return 1;
      else if (mark >= depth)
         return depth - 1;
      else
         return mark;
   endfunction

endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [DW-1:0]                wdata,
   input  logic                         pop,
   output logic [DW-1:0]                rdata,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         empty,
   output logic                         full
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic [DW-1:0] slot [DEPTH];
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == FULL_LVL);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (do_push && (wp == AW'(g)))
            slot[g] <= wdata;
      end
   end

   assign rdata = slot[rp];
   assign level = cnt;

endmodule

// File: rtl/sp_wr_end.sv
module sp_wr_end
   import sp_stream_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pred,
   input  logic                       hold,
   input  logic [DW-1:0]              word,
   input  logic [$clog2(DEPTH)-1:0]   mark,
   output logic                       stall,
   output logic                       ch_valid,
   output logic [DW-1:0]              ch_word,
   input  logic                       ch_ready
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [CW-1:0] lvl;
   logic          f_empty, f_full;
   logic          ready_seen;
   logic          take;
   int unsigned   lvl_i;
   int unsigned   mark_i;

   // Ready is a promise for the next clock, so it is registered here.
   always_ff @(posedge clk) begin
      if (!rst_n) ready_seen <= 1'b0;
      else        ready_seen <= ch_ready;
   end

   assign take     = pred && !hold && !f_full;
   assign ch_valid = ready_seen && !f_empty;

   always_comb begin
      lvl_i  = int'(lvl);
      mark_i = eff_mark(int'(mark), DEPTH);
   end

   assign stall = pred && (lvl_i >= mark_i);

   sp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (take),
      .wdata (word),
      .pop   (ch_valid),
      .rdata (ch_word),
      .level (lvl),
      .empty (f_empty),
      .full  (f_full)
   );

endmodule

// File: rtl/sp_rd_end.sv
module sp_rd_end #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ch_valid,
   input  logic [DW-1:0]   ch_word,
   output logic            ch_ready,
   input  logic            pred,
   input  logic            hold,
   output logic [DW-1:0]   word,
   output logic            empty,
   output logic            stall
);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [CW:0] LIMIT = (CW+1)'(DEPTH);

   logic [CW-1:0] lvl;
   logic          f_empty, f_full;
   logic          use_word;
   logic [CW:0]   lvl_after;

   // Ready ignores a same-cycle consume so it never depends on the predicate.
   assign lvl_after = {1'b0, lvl} + (CW+1)'(ch_valid);
   assign ch_ready  = (lvl_after < LIMIT);
   assign use_word  = pred && !hold && !f_empty;
   assign stall     = pred && f_empty;
   assign empty     = f_empty;

   sp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (ch_valid),
      .wdata (ch_word),
      .pop   (use_word),
      .rdata (word),
      .level (lvl),
      .empty (f_empty),
      .full  (f_full)
   );

   logic unused_full;
   assign unused_full = f_full;

endmodule

// File: rtl/sp_stream_ports.sv
module sp_stream_ports #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_pred,
   input  logic                       wr_hold,
   input  logic [DW-1:0]              wr_word,
   input  logic [$clog2(DEPTH)-1:0]   wr_mark,
   output logic                       wr_stall,
   output logic                       tx_valid,
   output logic [DW-1:0]              tx_word,
   input  logic                       tx_ready,
   input  logic                       rx_valid,
   input  logic [DW-1:0]              rx_word,
   output logic                       rx_ready,
   input  logic                       rd_pred,
   input  logic                       rd_hold,
   output logic [DW-1:0]              rd_word,
   output logic                       rd_empty,
   output logic                       rd_stall
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sp_stream_ports: DEPTH must be a power of two and at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("sp_stream_ports: DW must be at least 1");
   end

   sp_wr_end #(.DW(DW), .DEPTH(DEPTH)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .pred     (wr_pred),
      .hold     (wr_hold),
      .word     (wr_word),
      .mark     (wr_mark),
      .stall    (wr_stall),
      .ch_valid (tx_valid),
      .ch_word  (tx_word),
      .ch_ready (tx_ready)
   );

   sp_rd_end #(.DW(DW), .DEPTH(DEPTH)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ch_valid (rx_valid),
      .ch_word  (rx_word),
      .ch_ready (rx_ready),
      .pred     (rd_pred),
      .hold     (rd_hold),
      .word     (rd_word),
      .empty    (rd_empty),
      .stall    (rd_stall)
   );

endmodule

// File: rtl/sp_stream_ports_chk.sv
module sp_stream_ports_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_pred,
   input logic wr_stall,
   input logic tx_valid,
   input logic tx_ready,
   input logic rx_valid,
   input logic rx_ready,
   input logic rd_pred,
   input logic rd_hold,
   input logic rd_empty,
   input logic rd_stall
);
   AST_RESET_IDLE: assert property (@(posedge clk)
      $rose(rst_n) |-> (rx_ready && !tx_valid && rd_empty)); // R1

   AST_VALID_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(tx_ready)); // R4

   AST_WR_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pred |-> !wr_stall); // R9

   AST_RD_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_pred |-> !rd_stall); // R9

   AST_EMPTY_WAITS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_empty && !rx_valid) |=> rd_empty); // R8

   AST_HOLD_KEEPS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_empty && rd_hold) |=> !rd_empty); // R10

   AST_STALL_WHEN_DRY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pred && rd_empty) |-> rd_stall); // R6

endmodule

bind sp_stream_ports sp_stream_ports_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_pred  (wr_pred),
   .wr_stall (wr_stall),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .rx_valid (rx_valid),
   .rx_ready (rx_ready),
   .rd_pred  (rd_pred),
   .rd_hold  (rd_hold),
   .rd_empty (rd_empty),
   .rd_stall (rd_stall)
);

// File: tb/sim_sp_stream_ports.sv
`timescale 1ns/1ps
module sim_sp_stream_ports;
   localparam int DW    = 32;
   localparam int DEPTH = 8;
   localparam int MW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_pred, wr_hold;
   logic [DW-1:0] wr_word;
   logic [MW-1:0] wr_mark;
   logic          wr_stall;
   logic          tx_valid;
   logic [DW-1:0] tx_word;
   logic          tx_ready;
   logic          rx_valid;
   logic [DW-1:0] rx_word;
   logic          rx_ready;
   logic          rd_pred, rd_hold;
   logic [DW-1:0] rd_word;
   logic          rd_empty, rd_stall;

   always #4 clk = ~clk;

   sp_stream_ports #(.DW(DW), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_pred(wr_pred), .wr_hold(wr_hold), .wr_word(wr_word), .wr_mark(wr_mark),
      .wr_stall(wr_stall), .tx_valid(tx_valid), .tx_word(tx_word), .tx_ready(tx_ready),
      .rx_valid(rx_valid), .rx_word(rx_word), .rx_ready(rx_ready),
      .rd_pred(rd_pred), .rd_hold(rd_hold), .rd_word(rd_word),
      .rd_empty(rd_empty), .rd_stall(rd_stall)
   );

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   logic [DW-1:0] wq[$];
   logic [DW-1:0] rq[$];
   bit            seen_rdy;
   bit            prev_rx_rdy;
   bit            rx_want;
   logic [DW-1:0] tx_seen[$];

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int mark_eff(input int m);
      if (m == 0) return 1;
      return m;
   endfunction

   // One region cycle: inputs are set, outputs compared, model advanced.
   task automatic cyc();
      bit e_stall_w, e_txv, e_rdy, e_empty, e_stall_r;
      int wn, rn;
      rx_valid = rx_want && prev_rx_rdy;
      #1;
      wn = wq.size();
      rn = rq.size();
      e_stall_w = wr_pred && (wn >= mark_eff(int'(wr_mark)));
      e_txv     = seen_rdy && (wn > 0);
      e_rdy     = (rn + int'(rx_valid)) < DEPTH;
      e_empty   = (rn == 0);
      e_stall_r = rd_pred && e_empty;
      chk(wr_stall == e_stall_w, "R2 wr_stall", DW'(wr_stall), DW'(e_stall_w));
      chk(tx_valid == e_txv, "R4 tx_valid", DW'(tx_valid), DW'(e_txv));
      if (e_txv && tx_valid) chk(tx_word == wq[0], "R4 tx_word", tx_word, wq[0]);
      chk(rx_ready == e_rdy, "R5 rx_ready", DW'(rx_ready), DW'(e_rdy));
      chk(rd_empty == e_empty, "R8 rd_empty", DW'(rd_empty), DW'(e_empty));
      chk(rd_stall == e_stall_r, "R6 rd_stall", DW'(rd_stall), DW'(e_stall_r));
      if (!e_empty) chk(rd_word == rq[0], "R7 rd_word", rd_word, rq[0]);
      // advance model (levels taken at start of cycle)
      if (e_txv) void'(wq.pop_front());
      if (wr_pred && !wr_hold && wn < DEPTH) wq.push_back(wr_word);
      seen_rdy = tx_ready;
      if (rd_pred && !rd_hold && rn > 0) void'(rq.pop_front());
      if (rx_valid) rq.push_back(rx_word);
      prev_rx_rdy = rx_ready;
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      wr_pred = 0; wr_hold = 0; wr_word = '0; wr_mark = MW'(4);
      tx_ready = 0; rx_want = 0; rx_word = '0; rd_pred = 0; rd_hold = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      idle_inputs();
      rx_valid = 0;
      seen_rdy = 0;
      prev_rx_rdy = 1;
      repeat (4) @(negedge clk);
      rst_n = 1;
      #1;
      // R1: reset state
      chk(!tx_valid, "R1 tx_valid", DW'(tx_valid), 0);
      chk(rx_ready, "R1 rx_ready", DW'(rx_ready), 1);
      chk(rd_empty, "R1 rd_empty", DW'(rd_empty), 1);
      chk(!wr_stall && !rd_stall, "R1 stalls", DW'({wr_stall, rd_stall}), 0);
      @(negedge clk);

      // R3/R2: fill egress with channel closed, mark 5, writes land to full
      wr_mark = MW'(5);
      for (int i = 0; i < 11; i++) begin
         wr_pred = 1; wr_word = 32'hA000_0000 + i;
         cyc();
      end
      // R10: hold blocks a write; R9: predicate low moves nothing
      wr_hold = 1; wr_word = 32'hDEAD_0001; tx_ready = 1; cyc();
      wr_hold = 0; wr_pred = 0; cyc();
      // R4: drain with ready; full + pop + attempted write in one cycle
      wr_pred = 1; wr_word = 32'hB000_0000;
      for (int i = 0; i < 12; i++) begin
         wr_pred = (i < 3); wr_word = 32'hB000_0000 + i;
         tx_ready = (i % 4 != 3);
         cyc();
      end
      wr_pred = 0; tx_ready = 0;

      // R5/R8: fill ingress with predicate low
      rx_want = 1;
      for (int i = 0; i < 12; i++) begin
         rx_word = 32'hC000_0000 + i;
         cyc();
      end
      rx_want = 0;
      // R10: hold with predicate high keeps words
      rd_pred = 1; rd_hold = 1; cyc(); cyc();
      rd_hold = 0;
      // R7: consume while new words arrive in the same cycle
      rx_want = 1;
      for (int i = 0; i < 14; i++) begin
         rx_word = 32'hD000_0000 + i;
         rx_want = (i < 6);
         cyc();
      end
      // R6: stalled on empty
      rx_want = 0; rd_pred = 1; cyc(); cyc();
      rd_pred = 0;

      // random mix on both sides
      for (int i = 0; i < 4000; i++) begin
         wr_pred  = ($urandom % 3) != 0;
         wr_hold  = ($urandom % 5) == 0;
         wr_word  = $urandom;
         wr_mark  = MW'($urandom % DEPTH);
         tx_ready = ($urandom % 3) != 0;
         rx_want  = ($urandom % 2) == 0;
         rx_word  = $urandom;
         rd_pred  = ($urandom % 3) != 0;
         rd_hold  = ($urandom % 5) == 0;
         cyc();
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule